// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block times the external memory bus of an 8-bit controller whose machine cycle lasts twelve oscillator clocks. A free-running phase counter splits each machine cycle into two six-clock halves. From the phase and a per-cycle descriptor, the block produces four outputs: an address latch pulse, an active-low code fetch strobe, and active-low data read and write strobes. It also drives the multiplexed low address and data byte and the high address byte. It has no CPU core and does no instruction decoding. The core places its requests on the inputs, and the block samples them once, in the last clock of every machine cycle.

A machine cycle takes one of four kinds. In an external fetch cycle, the latch pulse and the fetch strobe each fire twice. In an internal execution cycle there is no bus traffic, although the latch pulse keeps running unless a disable bit silences it. An external data read or write cycle has a single latch pulse that carries the data address, followed by a six-clock read or write strobe. In a data cycle both fetch strobes and the second latch pulse are dropped. A width select chooses where the data address comes from. With the wide form, the high byte comes from a 16-bit pointer. With the narrow form, the low byte comes from an 8-bit pointer and the high byte is the port-2 register image.

All outputs are registered. Phase 0 of the first machine cycle appears on the first clock edge after reset is released.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: In fetch and internal cycles with the latch pulse enabled, `ale` is high for exactly 2 clocks starting at phases 0 and 6 of the 12-phase cycle, so it runs at one sixth of the clock rate.
- R2: In a data cycle (`xd_req`=1), `ale` is high only in phases 0 and 1. The pulse that would start at phase 6 is omitted.
- R3: In an external fetch cycle (`ext_exec`=1, `xd_req`=0), `psen_n` is low in phases 3 to 5 and 9 to 11. It stays high for the whole of every data cycle and every internal cycle, and it is never low while `ale` is high.
- R4: `rd_n` (when `xd_write`=0) or `wr_n` (when `xd_write`=1) is low for exactly phases 5 to 10 of a data cycle. It is high again in phase 11, one clock before the next latch pulse. The two strobes are never low together, and neither is ever low together with `psen_n`.
- R5: When `ale_off`=1 and `ext_exec`=0, `ale` stays low through fetch and internal cycles but still pulses in data cycles. When `ext_exec`=1, `ale_off` has no effect.
- R6: `p2_out` carries the high byte of `dptr` for a wide data access (`xd_wide`=1) and `p2_sfr` for a narrow one. In a fetch cycle it carries the high byte of `pc_addr`, and in an internal cycle it carries `p2_sfr`.
- R7: `p0_oe` is 1 and `p0_out` carries the low address in phases 0 to 2 of a data cycle, and in phases 0 to 2 and 6 to 8 of a fetch cycle. That covers the latch-high clocks plus one clock after the fall. The low address is `pc_addr[7:0]` for fetch, `dptr[7:0]` for a wide access, and `ri_ptr` for a narrow access.
- R8: In a write cycle, `p0_out` holds `wr_data` with `p0_oe`=1 from phase 3 through phase 11, so the data is stable before `wr_n` falls and after it rises. In a read cycle, and in internal cycles, `p0_oe`=0 and `p0_out`=0 whenever no address is driven.
- R9: Request, address, strap and control inputs are sampled only in phase 11. Changes during phases 0 to 10 have no effect on the cycle in progress.
- R10: While `rst_n`=0, `ale`=0, all strobes are high, and `p0_oe`, `p0_out` and `p2_out` are 0. The phase then advances by one per clock and wraps from 11 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_exec | input | 1 | Strap: code is fetched from external memory |
| ale_off | input | 1 | Register bit that silences the latch pulse outside data cycles |
| xd_req | input | 1 | Next machine cycle is an external data access |
| xd_write | input | 1 | Data access is a write (1) or a read (0) |
| xd_wide | input | 1 | Data access uses the 16-bit pointer (1) or the 8-bit pointer (0) |
| pc_addr | input | 16 | Code fetch address |
| dptr | input | 16 | 16-bit data pointer |
| ri_ptr | input | 8 | 8-bit data pointer |
| p2_sfr | input | 8 | Port-2 register image |
| wr_data | input | 8 | Byte to write |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Code fetch read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Multiplexed low address / write data |
| p0_oe | output | 1 | Drive enable for `p0_out` |
| p2_out | output | 8 | High address byte |

## Verification
The sequence runs external fetch cycles, then wide reads and narrow writes back to back, then internal cycles with the disable bit both clear and set, and finally fetch cycles with the disable bit set. This shows:
- the second latch pulse and the fetch strobes are dropped only in data cycles;
- the disable bit acts only when the strap is low;
- the port-2 source follows the width select.

Two cycles have their inputs scrambled in the middle. These separate a design that samples only at the cycle boundary from one that follows the live inputs. Every clock is compared against an expected trace, so an off-by-one in any window edge shows up as a wrong phase.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
   typedef enum logic [1:0] {
      MC_INT   = 2'd0,
      MC_FETCH = 2'd1,
      MC_DRD   = 2'd2,
      MC_DWR   = 2'd3
   } mc_kind_e;
endpackage

// File: rtl/ebs_phase.sv
module ebs_phase #(
   parameter  int CLKS = 12,
   localparam int PW   = $clog2(CLKS)
)(
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] ph,
   output logic [PW-1:0] ph_nxt,
   output logic          at_last
);
   localparam logic [PW-1:0] LAST = PW'(CLKS - 1);

   assign at_last = (ph == LAST);
   assign ph_nxt  = at_last ? '0 : ph + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) ph <= LAST;
      else        ph <= ph_nxt;
   end

   // R10: phase wraps at the end of the machine cycle
   p_phase_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == LAST) |=> (ph == '0));
   // R10: phase advances by one inside the machine cycle
   p_phase_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != LAST) |=> (ph == $past(ph) + 1'b1));
endmodule

// File: rtl/ebs_cycle_sel.sv
module ebs_cycle_sel import ebs_pkg::*; #(
   parameter int BW = 8
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            ext_exec,
   input  logic            ale_off,
   input  logic            xd_req,
   input  logic            xd_write,
   input  logic            xd_wide,
   input  logic [2*BW-1:0] pc_addr,
   input  logic [2*BW-1:0] dptr,
   input  logic [BW-1:0]   ri_ptr,
   input  logic [BW-1:0]   p2_sfr,
   input  logic [BW-1:0]   wr_data,
   output mc_kind_e        kind_nxt,
   output logic            ale_on_nxt,
   output logic [BW-1:0]   lo_nxt,
   output logic [BW-1:0]   hi_nxt,
   output logic [BW-1:0]   wd_nxt
);
   mc_kind_e      kind_s, kind_q;
   logic          ale_on_s, ale_on_q;
   logic [BW-1:0] lo_s, hi_s, lo_q, hi_q, wd_q;

   always_comb begin
      if (!xd_req) kind_s = ext_exec ? MC_FETCH : MC_INT;
      else         kind_s = xd_write ? MC_DWR : MC_DRD;
      ale_on_s = ext_exec | ~ale_off;
      if (xd_req) begin
         lo_s = xd_wide ? dptr[BW-1:0]    : ri_ptr;
         hi_s = xd_wide ? dptr[2*BW-1:BW] : p2_sfr;
      end else begin
         lo_s = pc_addr[BW-1:0];
         hi_s = ext_exec ? pc_addr[2*BW-1:BW] : p2_sfr;
      end
   end

   assign kind_nxt   = take ? kind_s   : kind_q;
   assign ale_on_nxt = take ? ale_on_s : ale_on_q;
   assign lo_nxt     = take ? lo_s     : lo_q;
   assign hi_nxt     = take ? hi_s     : hi_q;
   assign wd_nxt     = take ? wr_data  : wd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q   <= MC_INT;
         ale_on_q <= 1'b0;
         lo_q     <= '0;
         hi_q     <= '0;
         wd_q     <= '0;
      end else begin
         kind_q   <= kind_nxt;
         ale_on_q <= ale_on_nxt;
         lo_q     <= lo_nxt;
         hi_q     <= hi_nxt;
         wd_q     <= wd_nxt;
      end
   end
endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen import ebs_pkg::*; #(
   parameter int CLKS   = 12,
   parameter int ALE_W  = 2,
   parameter int PSEN_W = 3,
   parameter int STB_W  = 6,
   localparam int PW    = $clog2(CLKS)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] ph_nxt,
   input  mc_kind_e      kind_nxt,
   input  logic          ale_on_nxt,
   output logic          ale,
   output logic          psen_n,
   output logic          rd_n,
   output logic          wr_n
);
   localparam int            HALF = CLKS / 2;
   localparam logic [PW-1:0] S0   = PW'(CLKS - 1 - STB_W);

   logic [1:0]    win_ale, win_psen;
   logic [PW-1:0] ds;
   logic          stb_win, is_data;
   logic          ale_d, psen_d, rd_d, wr_d;

   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [PW-1:0] A0 = PW'(h * HALF);
      localparam logic [PW-1:0] P0 = PW'((h + 1) * HALF - PSEN_W);
      logic [PW-1:0] da, dp;
      assign da          = ph_nxt - A0;
      assign dp          = ph_nxt - P0;
      assign win_ale[h]  = da < PW'(ALE_W);
      assign win_psen[h] = dp < PW'(PSEN_W);
   end

   assign ds      = ph_nxt - S0;
   assign stb_win = ds < PW'(STB_W);
   assign is_data = (kind_nxt == MC_DRD) || (kind_nxt == MC_DWR);

   always_comb begin
      ale_d  = is_data ? win_ale[0] : (ale_on_nxt & (|win_ale));
      psen_d = ~((kind_nxt == MC_FETCH) & (|win_psen));
      rd_d   = ~((kind_nxt == MC_DRD) & stb_win);
      wr_d   = ~((kind_nxt == MC_DWR) & stb_win);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ale    <= 1'b0;
         psen_n <= 1'b1;
         rd_n   <= 1'b1;
         wr_n   <= 1'b1;
      end else begin
         ale    <= ale_d;
         psen_n <= psen_d;
         rd_n   <= rd_d;
         wr_n   <= wr_d;
      end
   end

   // R4: read and write strobes never overlap
   p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   // R4: fetch strobe never overlaps a data strobe
   p_psen_data_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!psen_n && !(rd_n && wr_n)));
   // R3: fetch strobe never low while the latch pulse is high
   p_ale_psen_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ale && !psen_n));
endmodule

// File: rtl/ebs_addr_mux.sv
module ebs_addr_mux import ebs_pkg::*; #(
   parameter int CLKS  = 12,
   parameter int ALE_W = 2,
   parameter int BW    = 8,
   localparam int PW   = $clog2(CLKS)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] ph_nxt,
   input  mc_kind_e      kind_nxt,
   input  logic [BW-1:0] lo_nxt,
   input  logic [BW-1:0] hi_nxt,
   input  logic [BW-1:0] wd_nxt,
   output logic [BW-1:0] p0_out,
   output logic          p0_oe,
   output logic [BW-1:0] p2_out
);
   localparam int HALF  = CLKS / 2;
   localparam int ADR_W = ALE_W + 1;

   logic [1:0]    win_adr;
   logic          oe_d;
   logic [BW-1:0] p0_d;

   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [PW-1:0] A0 = PW'(h * HALF);
      logic [PW-1:0] da;
      assign da         = ph_nxt - A0;
      assign win_adr[h] = da < PW'(ADR_W);
   end

   always_comb begin
      oe_d = 1'b0;
      p0_d = '0;
      unique case (kind_nxt)
         MC_FETCH: begin
            oe_d = |win_adr;
            p0_d = oe_d ? lo_nxt : '0;
         end
         MC_DRD: begin
            oe_d = win_adr[0];
            p0_d = oe_d ? lo_nxt : '0;
         end
         MC_DWR: begin
            oe_d = 1'b1;
            p0_d = win_adr[0] ? lo_nxt : wd_nxt;
         end
         default: begin
            oe_d = 1'b0;
            p0_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p0_out <= '0;
         p0_oe  <= 1'b0;
         p2_out <= '0;
      end else begin
         p0_out <= p0_d;
         p0_oe  <= oe_d;
         p2_out <= hi_nxt;
      end
   end

   // R8: released bus carries zero
   p_p0_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !p0_oe |-> (p0_out == '0));
endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq import ebs_pkg::*; #(
   parameter int CLKS_PER_MC = 12,
   parameter int ALE_CLKS    = 2,
   parameter int PSEN_CLKS   = 3,
   parameter int STB_CLKS    = 6,
   parameter int BYTE_W      = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_exec,
   input  logic              ale_off,
   input  logic              xd_req,
   input  logic              xd_write,
   input  logic              xd_wide,
   input  logic [2*BYTE_W-1:0] pc_addr,
   input  logic [2*BYTE_W-1:0] dptr,
   input  logic [BYTE_W-1:0] ri_ptr,
   input  logic [BYTE_W-1:0] p2_sfr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [BYTE_W-1:0] p0_out,
   output logic              p0_oe,
   output logic [BYTE_W-1:0] p2_out
);
   localparam int PH_W = $clog2(CLKS_PER_MC);
   localparam int HALF = CLKS_PER_MC / 2;

   if (CLKS_PER_MC % 2 != 0) begin : g_chk_even
      $error("machine cycle length must be even");
   end
   if (ALE_CLKS < 1 || ALE_CLKS + 1 > HALF - PSEN_CLKS) begin : g_chk_half
      $error("latch pulse, address hold and fetch strobe must fit one half cycle");
   end
   if (STB_CLKS < 1 || CLKS_PER_MC - 1 - STB_CLKS <= ALE_CLKS + 1) begin : g_chk_stb
      $error("data strobe must start after write data is placed");
   end

   logic [PH_W-1:0]   ph, ph_nxt;
   logic              at_last;
   mc_kind_e          kind_nxt;
   logic              ale_on_nxt;
   logic [BYTE_W-1:0] lo_nxt, hi_nxt, wd_nxt;

   ebs_phase #(.CLKS(CLKS_PER_MC)) u_phase (
      .clk(clk), .rst_n(rst_n), .ph(ph), .ph_nxt(ph_nxt), .at_last(at_last));

   ebs_cycle_sel #(.BW(BYTE_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .take(at_last),
      .ext_exec(ext_exec), .ale_off(ale_off), .xd_req(xd_req),
      .xd_write(xd_write), .xd_wide(xd_wide), .pc_addr(pc_addr),
      .dptr(dptr), .ri_ptr(ri_ptr), .p2_sfr(p2_sfr), .wr_data(wr_data),
      .kind_nxt(kind_nxt), .ale_on_nxt(ale_on_nxt),
      .lo_nxt(lo_nxt), .hi_nxt(hi_nxt), .wd_nxt(wd_nxt));

   ebs_strobe_gen #(.CLKS(CLKS_PER_MC), .ALE_W(ALE_CLKS), .PSEN_W(PSEN_CLKS),
                    .STB_W(STB_CLKS)) u_stb (
      .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt), .kind_nxt(kind_nxt),
      .ale_on_nxt(ale_on_nxt), .ale(ale), .psen_n(psen_n),
      .rd_n(rd_n), .wr_n(wr_n));

   ebs_addr_mux #(.CLKS(CLKS_PER_MC), .ALE_W(ALE_CLKS), .BW(BYTE_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt), .kind_nxt(kind_nxt),
      .lo_nxt(lo_nxt), .hi_nxt(hi_nxt), .wd_nxt(wd_nxt),
      .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out));

   // R7: a driven address stays on the bus one clock past the latch fall
   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ale) && $past(p0_oe)) |-> p0_oe);
   // R8: write data is driven and steady while the write strobe is low
   p_wdata_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (p0_oe && $stable(p0_out)));
   // R8: write data still held in the clock the write strobe rises
   p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (p0_oe && $stable(p0_out)));
   // R4: every strobe is inactive when a latch pulse starts
   p_ale_rise_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |-> (rd_n && wr_n && psen_n));
endmodule

// File: tb/tb_ext_bus_strobe_seq.sv
module tb_ext_bus_strobe_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_exec = 1'b0, ale_off = 1'b0, xd_req = 1'b0, xd_write = 1'b0, xd_wide = 1'b0;
   logic [15:0] pc_addr = '0, dptr = '0;
   logic [7:0]  ri_ptr = '0, p2_sfr = '0, wr_data = '0;
   logic ale, psen_n, rd_n, wr_n, p0_oe;
   logic [7:0] p0_out, p2_out;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [20:0] q_exp[$];
   string       q_atag[$];
   string       q_xtag[$];
   int          q_ph[$];

   always #4 clk = ~clk;

   ext_bus_strobe_seq dut (
      .clk(clk), .rst_n(rst_n), .ext_exec(ext_exec), .ale_off(ale_off),
      .xd_req(xd_req), .xd_write(xd_write), .xd_wide(xd_wide),
      .pc_addr(pc_addr), .dptr(dptr), .ri_ptr(ri_ptr), .p2_sfr(p2_sfr),
      .wr_data(wr_data), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
      .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out));

   task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s at %0t: got %h expected %h", tag, what, $time, got, exp);
      end
   endtask

   function automatic logic [20:0] exp_vec(int p, bit ext, bit aoff, bit req, bit wr,
         bit wide, logic [15:0] pc, logic [15:0] dp, logic [7:0] ri,
         logic [7:0] p2r, logic [7:0] wd);
      bit e_ale, e_psen, e_rd, e_wr, e_oe;
      logic [7:0] e_p0, e_p2;
      if (req) begin
         e_ale  = (p <= 1);
         e_psen = 1'b1;
         e_rd   = !(!wr && p >= 5 && p <= 10);
         e_wr   = !(wr && p >= 5 && p <= 10);
         e_oe   = (p <= 2) || wr;
         e_p0   = (p <= 2) ? (wide ? dp[7:0] : ri) : (wr ? wd : 8'h00);
         e_p2   = wide ? dp[15:8] : p2r;
      end else begin
         e_ale  = (p == 0 || p == 1 || p == 6 || p == 7) && (ext || !aoff);
         e_psen = !(ext && ((p >= 3 && p <= 5) || p >= 9));
         e_rd   = 1'b1;
         e_wr   = 1'b1;
         e_oe   = ext && ((p <= 2) || (p >= 6 && p <= 8));
         e_p0   = e_oe ? pc[7:0] : 8'h00;
         e_p2   = ext ? pc[15:8] : p2r;
      end
      return {e_ale, e_psen, e_rd, e_wr, e_oe, e_p0, e_p2};
   endfunction

   // driver: sets one machine cycle's inputs and queues its 12-clock trace
   task automatic run_mc(string atag, string xtag, bit ext, bit aoff, bit req, bit wr,
         bit wide, logic [15:0] pc, logic [15:0] dp, logic [7:0] ri,
         logic [7:0] p2r, logic [7:0] wd, bit perturb);
      ext_exec = ext; ale_off = aoff; xd_req = req; xd_write = wr; xd_wide = wide;
      pc_addr = pc; dptr = dp; ri_ptr = ri; p2_sfr = p2r; wr_data = wd;
      for (int p = 0; p < 12; p++) begin
         q_exp.push_back(exp_vec(p, ext, aoff, req, wr, wide, pc, dp, ri, p2r, wd));
         q_atag.push_back(atag);
         q_xtag.push_back(xtag);
         q_ph.push_back(p);
      end
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (perturb && i == 5) begin
            ext_exec = ~ext; ale_off = ~aoff; xd_req = ~req; xd_write = ~wr;
            xd_wide = ~wide; pc_addr = ~pc; dptr = ~dp; ri_ptr = ~ri;
            p2_sfr = ~p2r; wr_data = ~wd;
         end
      end
   endtask

   // monitor: compare every clock against the queued trace
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_exp.size() > 0) begin
            logic [20:0] e;
            string at, xt, pt;
            int ph;
            e  = q_exp.pop_front();
            at = q_atag.pop_front();
            xt = q_xtag.pop_front();
            ph = q_ph.pop_front();
            pt = ((ph <= 2) || (ph >= 6 && ph <= 8)) ? "R7" : "R8";
            chk({xt, at}, $sformatf("ale ph%0d", ph), {15'd0, ale}, {15'd0, e[20]});
            chk({xt, "R3"}, $sformatf("psen_n ph%0d", ph), {15'd0, psen_n}, {15'd0, e[19]});
            chk({xt, "R4"}, $sformatf("rd_n/wr_n ph%0d", ph), {14'd0, rd_n, wr_n}, {14'd0, e[18:17]});
            chk({xt, pt}, $sformatf("p0_oe/p0 ph%0d", ph), {7'd0, p0_oe, p0_out}, {7'd0, e[16:8]});
            chk({xt, "R6"}, $sformatf("p2 ph%0d", ph), {8'd0, p2_out}, {8'd0, e[7:0]});
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "reset ale", {15'd0, ale}, 16'd0);
      chk("R10", "reset strobes", {13'd0, psen_n, rd_n, wr_n}, 16'h0007);
      chk("R10", "reset p0", {7'd0, p0_oe, p0_out}, 16'd0);
      chk("R10", "reset p2", {8'd0, p2_out}, 16'd0);
      rst_n = 1'b1;
      // first cycle right after reset: phase alignment (R10), fetch timing R1
      run_mc("R1", "R10 ", 1, 0, 0, 0, 0, 16'h12A5, 16'h0, 8'h0, 8'h3C, 8'h0, 0);
      run_mc("R1", "", 1, 0, 0, 0, 0, 16'hB7C3, 16'h0, 8'h0, 8'h3C, 8'h0, 0);
      // data read, wide pointer: R2
      run_mc("R2", "", 1, 0, 1, 0, 1, 16'h1111, 16'h9A4E, 8'h55, 8'h3C, 8'h00, 0);
      // data write, narrow pointer, back to back
      run_mc("R2", "", 1, 0, 1, 1, 0, 16'h1111, 16'h9A4E, 8'h71, 8'hD2, 8'hE8, 0);
      run_mc("R2", "", 1, 0, 1, 0, 0, 16'h1111, 16'h0F0F, 8'h29, 8'h84, 8'h00, 0);
      // internal execution, latch pulse enabled
      run_mc("R1", "", 0, 0, 0, 0, 0, 16'h4321, 16'h0, 8'h0, 8'h6B, 8'h0, 0);
      // internal execution, latch pulse disabled: R5
      run_mc("R5", "", 0, 1, 0, 0, 0, 16'h4321, 16'h0, 8'h0, 8'h6B, 8'h0, 0);
      // disabled, but a data read still pulses: R5
      run_mc("R5", "", 0, 1, 1, 0, 0, 16'h4321, 16'h0, 8'hC4, 8'h6B, 8'h0, 0);
      // disable bit ignored under external execution: R5
      run_mc("R5", "", 1, 1, 0, 0, 0, 16'h5AF0, 16'h0, 8'h0, 8'h6B, 8'h0, 0);
      // mid-cycle input changes ignored: R9
      run_mc("R2", "R9 ", 1, 0, 1, 1, 1, 16'h2468, 16'hCE13, 8'h0, 8'h6B, 8'hA7, 1);
      run_mc("R1", "R9 ", 1, 0, 0, 0, 0, 16'h8E01, 16'h0, 8'h0, 8'h6B, 8'h0, 1);
      run_mc("R5", "", 0, 1, 0, 0, 0, 16'h0, 16'h0, 8'h0, 8'h99, 8'h0, 0);
      repeat (2) @(negedge clk);
      chk("R10", "trace fully consumed", 16'(q_exp.size()), 16'd0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule